// File: doc/BRIEF.md
# Frame-Transfer Area Sensor Clock Sequencer

This block produces every logic-level clock and strobe that a frame-transfer area image sensor needs. The sensor has a light-sensitive image section, a shielded storage section of the same height, and a horizontal output register. The sequencer alternates without end between two phases. During exposure the image clocks stay parked so that charge builds up, while the storage section is emptied one row at a time into the horizontal register and read out pixel by pixel. During the frame shift the image and storage clocks run together to move the whole exposed frame into storage. In that phase the horizontal register is idle and a drive-level select asks the external level shifters for their higher swing.

Downstream black-level clamping and the sampling converter use the per-pixel and per-line region flags, the line and pixel indices, and a single-cycle frame-start marker. The exposure length is given in lines, and the sequencer never makes it shorter than one full storage readout. A run control starts the cycle. When it is dropped, the sequencer parks after the next frame shift has finished.

Top module: `ccdseq_top`

## Requirements
- R1: After reset, and while run_i stays low, the sequencer is idle. img_ph_o and sto_ph_o rest at 4'b1100, hreg_ph_o at 3'b001, and every strobe, flag, index, sto_sel_o and boost_o is low or zero.
- R2: With run_i high in the idle state, a frame shift begins in the next clock cycle.
- R3: Each four-phase group moves one row by stepping its 4-bit port through 4'b1100, 4'b0110, 4'b0011, 4'b1001, holding each value STEP_CLKS clocks, and then returns to 4'b1100. When a group is not stepping, its port holds.
- R4: A frame shift consists of exactly ROW_BLACK+ROW_ACTIVE row patterns in which img_ph_o and sto_ph_o are equal. During it boost_o is high, sto_sel_o is low, hreg_ph_o is frozen and no strobe fires. boost_o is low in every other state.
- R5: Each line opens with a row shift. sto_sel_o is high, sto_ph_o runs one row pattern, img_ph_o stays at 4'b1100, hreg_ph_o is frozen and no strobe fires.
- R6: The pixel shift of each line follows its row shift. sto_sel_o is low and sto_ph_o holds 4'b1100. There are PIX_PER_LINE pixel periods of four clocks each. rst_gate_o fires in slot 0, samp_rst_o in slot 1 and samp_sig_o in slot 3. hreg_ph_o advances at the start of slot 2 through 3'b001, 3'b010, 3'b100 cyclically, and the rotation carries over from one line to the next.
- R7: During a pixel shift pix_idx_o counts the pixel periods from 0. Exactly one region flag is high: pix_black_o for the first PIX_BLACK and the last PIX_BLACK pixels, pix_over_o for the PIX_OVER pixels on each side of the active run, and pix_active_o for the PIX_ACTIVE pixels in the middle. All three flags are low outside pixel shifts.
- R8: line_idx_o numbers the exposure lines from 0 during row and pixel shifts and is zero otherwise. row_black_o is high for lines below ROW_BLACK, and row_active_o for the next ROW_ACTIVE lines. Neither flag is high for any other line or state.
- R9: An exposure lasts max(E, ROW_BLACK+ROW_ACTIVE) lines. E is the value of exp_lines_i captured when the frame shift hands over to exposure. Changes to exp_lines_i during exposure have no effect.
- R10: frame_start_o is a one-cycle pulse in slot 0 of pixel 0 of line 0 of every exposure.
- R11: If run_i is low when a frame shift ends, the sequencer goes idle with the R1 resting levels, except that hreg_ph_o keeps its rotation. Raising run_i again starts a new frame shift in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run control |
| exp_lines_i | input | EXP_W | Exposure length in lines |
| img_ph_o | output | 4 | Image-section clock phases |
| sto_ph_o | output | 4 | Storage-section clock phases |
| hreg_ph_o | output | 3 | Horizontal-register clock phases |
| sto_sel_o | output | 1 | Storage/summing control, high during a row shift |
| rst_gate_o | output | 1 | Output-node reset pulse |
| samp_rst_o | output | 1 | Reset-level sampling strobe |
| samp_sig_o | output | 1 | Signal-level sampling strobe |
| boost_o | output | 1 | Drive-level select, high for the boosted level |
| line_idx_o | output | EXP_W | Current exposure line |
| pix_idx_o | output | PIX_W | Current pixel period in the line |
| pix_active_o | output | 1 | Active pixel flag |
| pix_black_o | output | 1 | Shielded pixel flag |
| pix_over_o | output | 1 | Transition pixel flag |
| row_black_o | output | 1 | Shielded line flag |
| row_active_o | output | 1 | Active line flag |
| frame_start_o | output | 1 | First pixel of an exposure |

## Verification
The assertions assume that the internal reset has been released. They also assume that exp_lines_i and run_i are sampled only at the two hand-over points, so the properties do not depend on those inputs holding still. The stimulus drives both inputs only at falling edges. It sweeps the exposure length below, at and just above the storage height, and then draws random values. exp_lines_i is also scrambled on every line of an exposure. run_i is dropped once during an exposure, which exercises the park and restart path.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_ROW   = 2'd2,
    ST_PIX   = 2'd3
  } seq_state_e;

  // two adjacent phases high, one step per index
  function automatic logic [3:0] quad_pattern(input logic [1:0] idx);
    logic [3:0] v;
    case (idx)
      2'd0:    v = 4'b1100;
      2'd1:    v = 4'b0110;
      2'd2:    v = 4'b0011;
      default: v = 4'b1001;
    endcase
    return v;
  endfunction

  function automatic logic [2:0] tri_pattern(input logic [1:0] idx);
    logic [2:0] v;
    case (idx)
      2'd0:    v = 3'b001;
      2'd1:    v = 3'b010;
      default: v = 3'b100;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ccdseq_quad_clk.sv
module ccdseq_quad_clk
  import ccdseq_pkg::*;
#(
  parameter int STEP_CLKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  output logic [3:0] ph_o,
  output logic       row_done_o
);

  localparam int SW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CLKS - 1);

  logic [SW-1:0] step_q, step_d;
  logic [1:0]    idx_q, idx_d;
  logic          step_last;

  always_comb begin
    step_last = (step_q == STEP_LAST);
    step_d    = step_q;
    idx_d     = idx_q;
    if (step_last) begin
      step_d = '0;
      idx_d  = idx_q + 2'd1;
    end else begin
      step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      idx_q  <= '0;
    end else if (adv_i) begin
      step_q <= step_d;
      idx_q  <= idx_d;
    end
  end

  assign ph_o       = quad_pattern(idx_q);
  assign row_done_o = adv_i && step_last && (idx_q == 2'd3);

  AST_QUAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ph_o)); // R3
  AST_QUAD_ROW_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_done_o |=> (ph_o == 4'b1100)); // R3

endmodule

// File: rtl/ccdseq_pix_seq.sv
module ccdseq_pix_seq
  import ccdseq_pkg::*;
#(
  parameter int PIX_PER_LINE = 1072,
  parameter int PIX_W        = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [PIX_W-1:0] pix_o,
  output logic [2:0]       hph_o,
  output logic             rst_gate_o,
  output logic             samp_rst_o,
  output logic             samp_sig_o,
  output logic             line_done_o
);

  localparam logic [1:0] SLOT_RG  = 2'd0;
  localparam logic [1:0] SLOT_SHR = 2'd1;
  localparam logic [1:0] SLOT_ADV = 2'd2;
  localparam logic [1:0] SLOT_SHS = 2'd3;
  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX_PER_LINE - 1);

  logic [1:0]       slot_q, slot_d;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic [1:0]       hidx_q, hidx_d;
  logic             pix_last, h_en;

  always_comb begin
    pix_last = (pix_q == PIX_LAST);
    slot_d   = slot_q + 2'd1;
    pix_d    = pix_q;
    if (slot_q == SLOT_SHS) begin
      pix_d = pix_last ? '0 : pix_q + 1'b1;
    end
    hidx_d = (hidx_q == 2'd2) ? 2'd0 : hidx_q + 2'd1;
    // register updates at the edge ending the slot before SLOT_ADV
    h_en   = run_i && (slot_q == SLOT_ADV - 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      pix_q  <= '0;
    end else if (run_i) begin
      slot_q <= slot_d;
      pix_q  <= pix_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hidx_q <= '0;
    end else if (h_en) begin
      hidx_q <= hidx_d;
    end
  end

  assign pix_o       = pix_q;
  assign hph_o       = tri_pattern(hidx_q);
  assign rst_gate_o  = run_i && (slot_q == SLOT_RG);
  assign samp_rst_o  = run_i && (slot_q == SLOT_SHR);
  assign samp_sig_o  = run_i && (slot_q == SLOT_SHS);
  assign line_done_o = run_i && (slot_q == SLOT_SHS) && pix_last;

  AST_RG_THEN_SHR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_gate_o |=> samp_rst_o); // R6
  AST_SHR_THEN_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_rst_o |=> (hph_o != $past(hph_o))); // R6
  AST_H_FROZEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(hph_o)); // R5

endmodule

// File: rtl/ccdseq_region.sv
module ccdseq_region #(
  parameter int PIX_BLACK  = 20,
  parameter int PIX_OVER   = 4,
  parameter int PIX_ACTIVE = 1024,
  parameter int ROW_BLACK  = 6,
  parameter int ROW_ACTIVE = 1024,
  parameter int PIX_W      = 11,
  parameter int LINE_W     = 16
) (
  input  logic              pix_valid_i,
  input  logic              line_valid_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              pix_active_o,
  output logic              pix_black_o,
  output logic              pix_over_o,
  output logic              row_black_o,
  output logic              row_active_o
);

  localparam int ACT_FIRST  = PIX_BLACK + PIX_OVER;
  localparam int TAIL_OVER  = ACT_FIRST + PIX_ACTIVE;
  localparam int TAIL_BLACK = TAIL_OVER + PIX_OVER;
  localparam logic [PIX_W-1:0]  P_OVER0  = PIX_W'(PIX_BLACK);
  localparam logic [PIX_W-1:0]  P_ACT0   = PIX_W'(ACT_FIRST);
  localparam logic [PIX_W-1:0]  P_OVER1  = PIX_W'(TAIL_OVER);
  localparam logic [PIX_W-1:0]  P_BLACK1 = PIX_W'(TAIL_BLACK);
  localparam logic [LINE_W-1:0] L_ACT0   = LINE_W'(ROW_BLACK);
  localparam logic [LINE_W-1:0] L_END    = LINE_W'(ROW_BLACK + ROW_ACTIVE);

  logic in_black, in_act;

  always_comb begin
    in_black     = (pix_i < P_OVER0) || (pix_i >= P_BLACK1);
    in_act       = (pix_i >= P_ACT0) && (pix_i < P_OVER1);
    pix_black_o  = pix_valid_i && in_black;
    pix_active_o = pix_valid_i && in_act;
    pix_over_o   = pix_valid_i && !in_black && !in_act;
    row_black_o  = line_valid_i && (line_i < L_ACT0);
    row_active_o = line_valid_i && (line_i >= L_ACT0) && (line_i < L_END);
  end

endmodule

// File: rtl/ccdseq_top.sv
module ccdseq_top
  import ccdseq_pkg::*;
#(
  parameter int PIX_BLACK  = 20,
  parameter int PIX_OVER   = 4,
  parameter int PIX_ACTIVE = 1024,
  parameter int ROW_BLACK  = 6,
  parameter int ROW_ACTIVE = 1024,
  parameter int STEP_CLKS  = 2,
  parameter int EXP_W      = 16,
  localparam int PIX_PER_LINE = 2 * (PIX_BLACK + PIX_OVER) + PIX_ACTIVE,
  localparam int PIX_W        = $clog2(PIX_PER_LINE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_lines_i,
  output logic [3:0]       img_ph_o,
  output logic [3:0]       sto_ph_o,
  output logic [2:0]       hreg_ph_o,
  output logic             sto_sel_o,
  output logic             rst_gate_o,
  output logic             samp_rst_o,
  output logic             samp_sig_o,
  output logic             boost_o,
  output logic [EXP_W-1:0] line_idx_o,
  output logic [PIX_W-1:0] pix_idx_o,
  output logic             pix_active_o,
  output logic             pix_black_o,
  output logic             pix_over_o,
  output logic             row_black_o,
  output logic             row_active_o,
  output logic             frame_start_o
);

  localparam int ROWS = ROW_BLACK + ROW_ACTIVE;
  localparam logic [EXP_W-1:0] ROWS_L = EXP_W'(ROWS);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  seq_state_e       state_q, state_d;
  logic [EXP_W-1:0] line_q, line_d, exp_q, exp_d, last_line;
  logic             line_en, exp_en, pix_run, in_line, line_done;
  logic [1:0]       grp_adv, grp_done;
  logic [3:0]       grp_ph [2];
  logic             rg;

  // group 0 = image section, group 1 = storage section
  assign grp_adv[0] = (state_q == ST_FRAME);
  assign grp_adv[1] = (state_q == ST_FRAME) || (state_q == ST_ROW);

  for (genvar g = 0; g < 2; g++) begin : g_quad
    ccdseq_quad_clk #(.STEP_CLKS(STEP_CLKS)) u_quad (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .adv_i      (grp_adv[g]),
      .ph_o       (grp_ph[g]),
      .row_done_o (grp_done[g])
    );
  end

  assign pix_run = (state_q == ST_PIX);
  assign in_line = (state_q == ST_ROW) || pix_run;

  ccdseq_pix_seq #(.PIX_PER_LINE(PIX_PER_LINE), .PIX_W(PIX_W)) u_pix (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (pix_run),
    .pix_o       (pix_idx_o),
    .hph_o       (hreg_ph_o),
    .rst_gate_o  (rg),
    .samp_rst_o  (samp_rst_o),
    .samp_sig_o  (samp_sig_o),
    .line_done_o (line_done)
  );

  assign last_line = (exp_q < ROWS_L) ? (ROWS_L - 1'b1) : (exp_q - 1'b1);

  always_comb begin
    state_d = state_q;
    line_d  = line_q;
    exp_d   = exp_q;
    line_en = 1'b0;
    exp_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (run_i) state_d = ST_FRAME;
      end
      ST_FRAME: begin
        if (grp_done[0]) begin
          line_en = 1'b1;
          if (line_q == ROWS_L - 1'b1) begin
            line_d = '0;
            if (run_i) begin
              state_d = ST_ROW;
              exp_d   = exp_lines_i;
              exp_en  = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            line_d = line_q + 1'b1;
          end
        end
      end
      ST_ROW: begin
        if (grp_done[1]) state_d = ST_PIX;
      end
      default: begin
        if (line_done) begin
          line_en = 1'b1;
          if (line_q == last_line) begin
            state_d = ST_FRAME;
            line_d  = '0;
          end else begin
            state_d = ST_ROW;
            line_d  = line_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      exp_q   <= '0;
    end else begin
      state_q <= state_d;
      if (line_en) line_q <= line_d;
      if (exp_en)  exp_q  <= exp_d;
    end
  end

  ccdseq_region #(
    .PIX_BLACK (PIX_BLACK),
    .PIX_OVER  (PIX_OVER),
    .PIX_ACTIVE(PIX_ACTIVE),
    .ROW_BLACK (ROW_BLACK),
    .ROW_ACTIVE(ROW_ACTIVE),
    .PIX_W     (PIX_W),
    .LINE_W    (EXP_W)
  ) u_region (
    .pix_valid_i (pix_run),
    .line_valid_i(in_line),
    .pix_i       (pix_idx_o),
    .line_i      (line_q),
    .pix_active_o(pix_active_o),
    .pix_black_o (pix_black_o),
    .pix_over_o  (pix_over_o),
    .row_black_o (row_black_o),
    .row_active_o(row_active_o)
  );

  assign img_ph_o      = grp_ph[0];
  assign sto_ph_o      = grp_ph[1];
  assign sto_sel_o     = (state_q == ST_ROW);
  assign boost_o       = (state_q == ST_FRAME);
  assign rst_gate_o    = rg;
  assign line_idx_o    = in_line ? line_q : '0;
  assign frame_start_o = rg && (line_q == '0) && (pix_idx_o == '0);

  AST_FRAME_GROUPS_EQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    boost_o |-> (img_ph_o == sto_ph_o)); // R4
  AST_H_FROZEN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_n)
    boost_o |-> $stable(hreg_ph_o)); // R4
  AST_IMG_REST_ROW: assert property (@(posedge clk_i) disable iff (!rst_n)
    sto_sel_o |-> (img_ph_o == 4'b1100)); // R5
  AST_H_FROZEN_ROW: assert property (@(posedge clk_i) disable iff (!rst_n)
    sto_sel_o |-> $stable(hreg_ph_o)); // R5
  AST_STO_HOLD_PIX: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pix_run && $past(pix_run)) |-> $stable(sto_ph_o)); // R6
  AST_REGION_ONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    pix_run |-> ($countones({pix_active_o, pix_black_o, pix_over_o}) == 1)); // R7
  AST_LINE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_line |-> (line_q <= last_line)); // R9
  AST_FS_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o); // R10

endmodule

// File: tb/ccdseq_top_tb_top.sv
module ccdseq_top_tb_top;

  localparam int PB    = 2;
  localparam int PO    = 1;
  localparam int PA    = 4;
  localparam int RB    = 1;
  localparam int RA    = 3;
  localparam int STEP  = 2;
  localparam int EXPW  = 8;
  localparam int PPL   = 2 * (PB + PO) + PA;
  localparam int PIXW  = $clog2(PPL);
  localparam int ROWS  = RB + RA;
  localparam int NFRM  = 9;
  localparam int STOPF = 5;

  typedef struct packed {
    logic [3:0] img;
    logic [3:0] sto;
    logic [2:0] h;
    logic       sel, boost, rg, shr, shs, fs, pa, pb, po, rb, ra;
    logic [7:0] line;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni, run_i;
  logic [EXPW-1:0] exp_lines_i;
  logic [3:0] img_ph_o, sto_ph_o;
  logic [2:0] hreg_ph_o;
  logic sto_sel_o, rst_gate_o, samp_rst_o, samp_sig_o, boost_o;
  logic [EXPW-1:0] line_idx_o;
  logic [PIXW-1:0] pix_idx_o;
  logic pix_active_o, pix_black_o, pix_over_o, row_black_o, row_active_o, frame_start_o;

  int checks = 0;
  int fails  = 0;
  int hcount = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ccdseq_top #(
    .PIX_BLACK(PB), .PIX_OVER(PO), .PIX_ACTIVE(PA),
    .ROW_BLACK(RB), .ROW_ACTIVE(RA), .STEP_CLKS(STEP), .EXP_W(EXPW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .exp_lines_i(exp_lines_i),
    .img_ph_o(img_ph_o), .sto_ph_o(sto_ph_o), .hreg_ph_o(hreg_ph_o),
    .sto_sel_o(sto_sel_o), .rst_gate_o(rst_gate_o), .samp_rst_o(samp_rst_o),
    .samp_sig_o(samp_sig_o), .boost_o(boost_o), .line_idx_o(line_idx_o),
    .pix_idx_o(pix_idx_o), .pix_active_o(pix_active_o), .pix_black_o(pix_black_o),
    .pix_over_o(pix_over_o), .row_black_o(row_black_o), .row_active_o(row_active_o),
    .frame_start_o(frame_start_o)
  );

  function automatic logic [3:0] pat4(input int i);
    case (i % 4)
      0:       return 4'b1100;
      1:       return 4'b0110;
      2:       return 4'b0011;
      default: return 4'b1001;
    endcase
  endfunction

  function automatic logic [2:0] h_of(input int n);
    return 3'(3'b001 << (n % 3));
  endfunction

  function automatic exp_t rest_exp();
    exp_t e;
    e = '0;
    e.img = 4'b1100;
    e.sto = 4'b1100;
    e.h   = h_of(hcount);
    return e;
  endfunction

  function automatic string pick(input string ovr, input string t);
    return (ovr != "") ? ovr : t;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h time=%0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic compare(input exp_t e, input string tph, input string ovr);
    chk(pick(ovr, tph),   "img_ph",   32'(img_ph_o),     32'(e.img));
    chk(pick(ovr, tph),   "sto_ph",   32'(sto_ph_o),     32'(e.sto));
    chk(pick(ovr, "R6"),  "hreg_ph",  32'(hreg_ph_o),    32'(e.h));
    chk(pick(ovr, "R5"),  "sto_sel",  32'(sto_sel_o),    32'(e.sel));
    chk(pick(ovr, "R4"),  "boost",    32'(boost_o),      32'(e.boost));
    chk(pick(ovr, "R6"),  "rst_gate", 32'(rst_gate_o),   32'(e.rg));
    chk(pick(ovr, "R6"),  "samp_rst", 32'(samp_rst_o),   32'(e.shr));
    chk(pick(ovr, "R6"),  "samp_sig", 32'(samp_sig_o),   32'(e.shs));
    chk(pick(ovr, "R10"), "fstart",   32'(frame_start_o), 32'(e.fs));
    chk(pick(ovr, "R7"),  "pix_act",  32'(pix_active_o), 32'(e.pa));
    chk(pick(ovr, "R7"),  "pix_blk",  32'(pix_black_o),  32'(e.pb));
    chk(pick(ovr, "R7"),  "pix_ovr",  32'(pix_over_o),   32'(e.po));
    chk(pick(ovr, "R8"),  "row_blk",  32'(row_black_o),  32'(e.rb));
    chk(pick(ovr, "R8"),  "row_act",  32'(row_active_o), 32'(e.ra));
    chk(pick(ovr, "R8"),  "line_idx", 32'(line_idx_o),   32'(e.line));
  endtask

  task automatic idle_cycles(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare(rest_exp(), "", tag);
    end
  endtask

  task automatic frame_shift(input string first_tag);
    exp_t e;
    for (int r = 0; r < ROWS; r++)
      for (int i = 0; i < 4; i++)
        for (int k = 0; k < STEP; k++) begin
          @(negedge clk);
          e = rest_exp();
          e.img = pat4(i);
          e.sto = pat4(i);
          e.boost = 1'b1;
          if (r == 0 && i == 0 && k == 0) chk(first_tag, "shift_begin", 32'(boost_o), 32'd1);
          compare(e, "R4", "");
        end
  endtask

  task automatic one_line(input int ln);
    exp_t e;
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < STEP; k++) begin
        @(negedge clk);
        e = rest_exp();
        e.sto  = pat4(i);
        e.sel  = 1'b1;
        e.line = 8'(ln);
        e.rb   = (ln < RB);
        e.ra   = (ln >= RB) && (ln < ROWS);
        compare(e, "R5", "");
        exp_lines_i = 8'($urandom_range(0, 255)); // R9: must be ignored
      end
    for (int p = 0; p < PPL; p++)
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        e = rest_exp();
        e.h    = h_of(hcount + p + ((s >= 2) ? 1 : 0));
        e.rg   = (s == 0);
        e.shr  = (s == 1);
        e.shs  = (s == 3);
        e.fs   = (ln == 0) && (p == 0) && (s == 0);
        e.pb   = (p < PB) || (p >= PPL - PB);
        e.po   = (p >= PB && p < PB + PO) || (p >= PB + PO + PA && p < PPL - PB);
        e.pa   = (p >= PB + PO) && (p < PB + PO + PA);
        e.line = 8'(ln);
        e.rb   = (ln < RB);
        e.ra   = (ln >= RB) && (ln < ROWS);
        compare(e, "R6", "");
        chk("R7", "pix_idx", 32'(pix_idx_o), 32'(p));
      end
    hcount += PPL;
  endtask

  initial begin
    int ev, nl;
    void'($urandom(32'd4711));
    rst_ni = 1'b0;
    run_i = 1'b0;
    exp_lines_i = '0;
    idle_cycles(3, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    idle_cycles(6, "R1");
    for (int f = 0; f < NFRM; f++) begin
      case (f)
        0: ev = 0;
        1: ev = ROWS - 1;
        2: ev = ROWS;
        3: ev = ROWS + 1;
        default: ev = int'($urandom_range(0, 12));
      endcase
      exp_lines_i = 8'(ev);
      run_i = (f != STOPF);
      frame_shift((f == 0) ? "R2" : "R9");
      if (f == STOPF) begin
        idle_cycles(5, "R11");
        run_i = 1'b1;
        frame_shift("R11");
      end
      nl = (ev < ROWS) ? ROWS : ev;
      for (int ln = 0; ln < nl; ln++) one_line(ln);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule